// File: doc/BRIEF.md
# Burst Mover for a Host Expansion Port

This block is the part of a host-facing expansion port that can take over the external bus for a short time and move a block of 32-bit words on its own. Software programs an internal-memory start address, an external-bus start address and a word count. It then writes a start code into a single 32-bit control word. The code picks the direction. An outbound burst copies words from internal memory onto the external bus. An inbound burst copies words from the external bus into internal memory. The block drives the external bus only while such a burst is running. At every other time it stays a passive slave.

Each word moves through a one-word staging register. The block first takes the word from the source side with a valid/ready handshake, then offers it to the sink side with a second handshake. After every word both addresses step forward by four bytes and the count goes down by one. When the count reaches zero, the start field returns to idle on its own.

An interrupt can come from one of two causes, chosen by a source field in the control word. One cause is the end of a burst. The other is a doorbell bit that an external master sets. The interrupt is a one-cycle pulse. It is also latched in a sticky flag that software clears by writing 1 to it.

Top module: `burst_master`

## Requirements
- R1: After reset, all three registers read zero, `irq` and `ext_master` are low, and every valid and ready output is low.
- R2: Writing the control word (select 0) with start field bits 1:0 = 01 and a non-zero count in bits 31:16 starts an outbound burst. Word k is read from internal address A_int+4k and appears on `ext_wdata` with `ext_addr` = A_ext+4k.
- R3: Start code 10 with a non-zero count starts an inbound burst. Word k is read from external address A_ext+4k and written to internal address A_int+4k.
- R4: Start codes 00 and 11, and any start code written with a count of zero, start nothing. Busy (bit 5) stays 0, the start field reads 00, and no handshake output is raised.
- R5: During a burst, the count field drops by one for each word delivered to the sink. After the burst, the internal address register (select 1) and the external address register (select 2) have each advanced by 4 times the starting count, wrapping at 2^32.
- R6: When the last word is delivered, the start field clears to 00 and busy clears to 0. Busy reads 1 for the whole of a burst.
- R7: While busy, writes to the start field, the count field and both address registers are ignored.
- R8: With the interrupt source field (bits 3:2) = 10, `irq` pulses high for exactly one cycle after the last word of a burst, and the sticky flag (bit 6) sets. Writing 1 to bit 6 clears it.
- R9: A high cycle on `doorbell_set` sets the doorbell bit (bit 4). With source field 01, this also gives a one-cycle `irq` pulse and sets the sticky flag. Writing 1 to bit 4 clears the doorbell bit.
- R10: With source field 01 or 00, the end of a burst raises no `irq`. With source field 00 or 10, the doorbell raises no `irq`.
- R11: `ext_master` is high exactly while a burst is running.
- R12: A word moves only when valid and ready are both high. While a push is offered but not accepted, the data and the address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 internal address, 2 external address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| doorbell_set | input | 1 | External master sets the doorbell bit |
| int_addr | output | 32 | Current internal-memory word address |
| int_rvalid | input | 1 | Internal memory offers read data |
| int_rready | output | 1 | Block accepts internal read data |
| int_rdata | input | 32 | Internal read data |
| int_wvalid | output | 1 | Block offers a word to internal memory |
| int_wready | input | 1 | Internal memory accepts the word |
| int_wdata | output | 32 | Word to internal memory |
| ext_addr | output | 32 | Current external-bus word address |
| ext_rvalid | input | 1 | External bus offers read data |
| ext_rready | output | 1 | Block accepts external read data |
| ext_rdata | input | 32 | External read data |
| ext_wvalid | output | 1 | Block offers a word to the external bus |
| ext_wready | input | 1 | External bus accepts the word |
| ext_wdata | output | 32 | Word to the external bus |
| ext_master | output | 1 | Block is currently master of the external bus |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The table runs bursts in both directions. The lengths range from a single word up to five words, and the starting addresses include one that wraps past 2^32. Each burst uses its own stall pattern on the source side and on the sink side. An all-ready pattern shows the fastest two-cycle rhythm per word. Irregular patterns separate a design that moves words only on a full handshake from one that drops or repeats words. Each vector also selects an interrupt source, so the same bursts show whether the count-end pulse depends on the selected cause. Directed tests then freeze the sink mid-burst to check that data stays held and that writes made while busy are ignored. Further directed tests cover start codes that should do nothing and the doorbell path under each source setting.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_FETCH = 2'd1,
        MV_PUSH  = 2'd2
    } mv_state_e;

    localparam logic [1:0] GO_OUTBOUND = 2'b01;
    localparam logic [1:0] GO_INBOUND  = 2'b10;
    localparam logic [1:0] CAUSE_BELL  = 2'b01;
    localparam logic [1:0] CAUSE_COUNT = 2'b10;

    localparam int BIT_BELL   = 4;
    localparam int BIT_BUSY   = 5;
    localparam int BIT_STICKY = 6;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_IADR = 2'd1;
    localparam logic [1:0] SEL_EADR = 2'd2;

endpackage

// File: rtl/bm_regs.sv
module bm_regs
    import bm_pkg::*;
#(
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          doorbell_set,
    input  logic          busy_i,
    input  logic          word_done_i,
    input  logic          sticky_i,
    output logic          go_o,
    output logic          dir_in_o,
    output logic          last_o,
    output logic          burst_end_o,
    output logic          bell_evt_o,
    output logic [1:0]    cause_o,
    output logic          sticky_clr_o,
    output logic          cnt_nz_o,
    output logic [DW-1:0] int_addr_o,
    output logic [DW-1:0] ext_addr_o
);

    localparam int PAD = DW - CW - 7;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    start;
        logic [1:0]    cause;
        logic          bell;
        logic [DW-1:0] iadr;
        logic [DW-1:0] eadr;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl;
    logic  unused_bits;

    assign unused_bits = ^{reg_wdata[DW-CW-1:7], reg_wdata[BIT_BUSY]};

    always_comb begin
        d            = q;
        wr_ctrl      = reg_wr && (reg_sel == SEL_CTRL);
        go_o         = wr_ctrl && !busy_i
                       && (reg_wdata[1:0] == GO_OUTBOUND || reg_wdata[1:0] == GO_INBOUND)
                       && (reg_wdata[DW-1:DW-CW] != '0);
        last_o       = (q.cnt == CW'(1));
        burst_end_o  = word_done_i && last_o;
        bell_evt_o   = doorbell_set && !q.bell;
        sticky_clr_o = wr_ctrl && reg_wdata[BIT_STICKY];

        if (wr_ctrl) begin
            d.cause = reg_wdata[3:2];
            if (!busy_i) begin
                d.cnt   = reg_wdata[DW-1:DW-CW];
                d.start = go_o ? reg_wdata[1:0] : 2'b00;
            end
            if (reg_wdata[BIT_BELL]) d.bell = 1'b0;
        end
        if (reg_wr && !busy_i && reg_sel == SEL_IADR) d.iadr = reg_wdata;
        if (reg_wr && !busy_i && reg_sel == SEL_EADR) d.eadr = reg_wdata;

        if (word_done_i) begin
            d.cnt  = q.cnt - CW'(1);
            d.iadr = q.iadr + DW'(STEP);
            d.eadr = q.eadr + DW'(STEP);
            if (last_o) d.start = 2'b00;
        end
        if (doorbell_set) d.bell = 1'b1;

        case (reg_sel)
            SEL_CTRL: reg_rdata = {q.cnt, {PAD{1'b0}}, sticky_i, busy_i, q.bell, q.cause, q.start};
            SEL_IADR: reg_rdata = q.iadr;
            SEL_EADR: reg_rdata = q.eadr;
            default:  reg_rdata = '0;
        endcase
    end

    assign dir_in_o   = (q.start == GO_INBOUND);
    assign cause_o    = q.cause;
    assign cnt_nz_o   = (q.cnt != '0);
    assign int_addr_o = q.iadr;
    assign ext_addr_o = q.eadr;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6
    busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (q.start == GO_OUTBOUND || q.start == GO_INBOUND));

    // R7
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !word_done_i) |=> $stable(q.iadr) && $stable(q.eadr));

endmodule

// File: rtl/bm_mover.sv
module bm_mover
    import bm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          dir_in_i,
    input  logic          last_i,
    input  logic          int_rvalid,
    output logic          int_rready,
    input  logic [DW-1:0] int_rdata,
    output logic          int_wvalid,
    input  logic          int_wready,
    output logic [DW-1:0] int_wdata,
    input  logic          ext_rvalid,
    output logic          ext_rready,
    input  logic [DW-1:0] ext_rdata,
    output logic          ext_wvalid,
    input  logic          ext_wready,
    output logic [DW-1:0] ext_wdata,
    output logic          busy_o,
    output logic          word_done_o
);

    typedef struct packed {
        mv_state_e     st;
        logic [DW-1:0] stage;
    } mv_t;

    mv_t  q, d;
    logic sink_rdy;

    always_comb begin
        d           = q;
        int_rready  = 1'b0;
        ext_rready  = 1'b0;
        int_wvalid  = 1'b0;
        ext_wvalid  = 1'b0;
        word_done_o = 1'b0;
        sink_rdy    = dir_in_i ? int_wready : ext_wready;

        case (q.st)
            MV_IDLE: if (go_i) d.st = MV_FETCH;
            MV_FETCH: begin
                int_rready = !dir_in_i;
                ext_rready = dir_in_i;
                if (dir_in_i ? ext_rvalid : int_rvalid) begin
                    d.stage = dir_in_i ? ext_rdata : int_rdata;
                    d.st    = MV_PUSH;
                end
            end
            MV_PUSH: begin
                int_wvalid = dir_in_i;
                ext_wvalid = !dir_in_i;
                if (sink_rdy) begin
                    word_done_o = 1'b1;
                    d.st        = last_i ? MV_IDLE : MV_FETCH;
                end
            end
            default: d.st = MV_IDLE;
        endcase
    end

    assign int_wdata = q.stage;
    assign ext_wdata = q.stage;
    assign busy_o    = (q.st != MV_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R12
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == MV_PUSH && !sink_rdy) |=> (q.st == MV_PUSH && $stable(q.stage)));

endmodule

// File: rtl/bm_irq.sv
module bm_irq
    import bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cause_i,
    input  logic       burst_end_i,
    input  logic       bell_evt_i,
    input  logic       sticky_clr_i,
    output logic       irq_o,
    output logic       sticky_o
);

    typedef struct packed {
        logic pulse;
        logic sticky;
    } irq_t;

    irq_t q, d;
    logic evt;

    always_comb begin
        d       = q;
        evt     = (cause_i == CAUSE_COUNT && burst_end_i)
               || (cause_i == CAUSE_BELL && bell_evt_i);
        d.pulse = evt;
        if (sticky_clr_i) d.sticky = 1'b0;
        if (evt)          d.sticky = 1'b1;
    end

    assign irq_o    = q.pulse;
    assign sticky_o = q.sticky;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> sticky_o);

endmodule

// File: rtl/burst_master.sv
module burst_master
    import bm_pkg::*;
#(
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          doorbell_set,
    output logic [DW-1:0] int_addr,
    input  logic          int_rvalid,
    output logic          int_rready,
    input  logic [DW-1:0] int_rdata,
    output logic          int_wvalid,
    input  logic          int_wready,
    output logic [DW-1:0] int_wdata,
    output logic [DW-1:0] ext_addr,
    input  logic          ext_rvalid,
    output logic          ext_rready,
    input  logic [DW-1:0] ext_rdata,
    output logic          ext_wvalid,
    input  logic          ext_wready,
    output logic [DW-1:0] ext_wdata,
    output logic          ext_master,
    output logic          irq
);

    logic       busy, word_done, sticky, go, dir_in, last;
    logic       burst_end, bell_evt, sticky_clr, cnt_nz;
    logic [1:0] cause;

    bm_regs #(.DW(DW), .CW(CW), .STEP(STEP)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .doorbell_set(doorbell_set),
        .busy_i(busy), .word_done_i(word_done), .sticky_i(sticky),
        .go_o(go), .dir_in_o(dir_in), .last_o(last), .burst_end_o(burst_end),
        .bell_evt_o(bell_evt), .cause_o(cause), .sticky_clr_o(sticky_clr),
        .cnt_nz_o(cnt_nz), .int_addr_o(int_addr), .ext_addr_o(ext_addr)
    );

    bm_mover #(.DW(DW)) u_mover (
        .clk(clk), .rst_n(rst_n), .go_i(go), .dir_in_i(dir_in), .last_i(last),
        .int_rvalid(int_rvalid), .int_rready(int_rready), .int_rdata(int_rdata),
        .int_wvalid(int_wvalid), .int_wready(int_wready), .int_wdata(int_wdata),
        .ext_rvalid(ext_rvalid), .ext_rready(ext_rready), .ext_rdata(ext_rdata),
        .ext_wvalid(ext_wvalid), .ext_wready(ext_wready), .ext_wdata(ext_wdata),
        .busy_o(busy), .word_done_o(word_done)
    );

    bm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cause_i(cause), .burst_end_i(burst_end),
        .bell_evt_i(bell_evt), .sticky_clr_i(sticky_clr),
        .irq_o(irq), .sticky_o(sticky)
    );

    assign ext_master = busy;

    // R5
    master_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_master |-> cnt_nz);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_master |-> !(ext_wvalid || ext_rready || int_wvalid || int_rready));

endmodule

// File: tb/sim_burst_master.sv
module sim_burst_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        doorbell_set = 1'b0;
    logic [31:0] int_addr, ext_addr, int_wdata, ext_wdata;
    logic        int_rvalid = 1'b0, int_wready = 1'b0;
    logic        ext_rvalid = 1'b0, ext_wready = 1'b0;
    logic [31:0] int_rdata = '0, ext_rdata = '0;
    logic        int_rready, int_wvalid, ext_rready, ext_wvalid, ext_master, irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .doorbell_set(doorbell_set),
        .int_addr(int_addr), .int_rvalid(int_rvalid), .int_rready(int_rready),
        .int_rdata(int_rdata), .int_wvalid(int_wvalid), .int_wready(int_wready),
        .int_wdata(int_wdata), .ext_addr(ext_addr), .ext_rvalid(ext_rvalid),
        .ext_rready(ext_rready), .ext_rdata(ext_rdata), .ext_wvalid(ext_wvalid),
        .ext_wready(ext_wready), .ext_wdata(ext_wdata), .ext_master(ext_master),
        .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  code;
        logic [1:0]  cause;
        logic [15:0] cnt;
        logic [31:0] ia;
        logic [31:0] ea;
        logic [7:0]  stall;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 2'b10, 16'd3, 32'h0000_0100, 32'h8000_0000, 8'h00},
        '{2'b10, 2'b10, 16'd4, 32'h0000_0200, 32'h4000_0010, 8'b1010_0110},
        '{2'b01, 2'b01, 16'd2, 32'hFFFF_FFF8, 32'h0000_0010, 8'b0011_0001},
        '{2'b10, 2'b00, 16'd5, 32'h0000_0040, 32'h9000_0000, 8'b1100_1000},
        '{2'b01, 2'b00, 16'd1, 32'h0000_0004, 32'h0000_0008, 8'b0111_0000}
    };

    function automatic logic [31:0] mem(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] ctrl(input logic [15:0] c, input logic [1:0] cause,
                                          input logic [1:0] code, input logic clr_bell,
                                          input logic clr_sticky);
        return {c, 9'd0, clr_sticky, 1'b0, clr_bell, cause, code};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic idle_bus();
        int_rvalid = 1'b0; int_wready = 1'b0; ext_rvalid = 1'b0; ext_wready = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] r;
        int k = 0;
        int cyc = 0;
        int pulses = 0;
        bit inb = (v.code == 2'b10);
        wr_reg(2'd1, v.ia);
        wr_reg(2'd2, v.ea);
        wr_reg(2'd0, ctrl(v.cnt, v.cause, v.code, 1'b0, 1'b1));
        chk(ext_master == 1'b1, "R11", {31'd0, ext_master}, 32'd1);
        while (k < int'(v.cnt) && cyc < 400) begin
            bit s_st = v.stall[cyc % 8];
            bit k_st = v.stall[(cyc + 3) % 8];
            if (inb) begin
                ext_rvalid = !s_st; ext_rdata = mem(ext_addr);
                int_wready = !k_st;
                if (int_wvalid && int_wready) begin
                    chk(int_addr == v.ia + 32'(4 * k), "R3", int_addr, v.ia + 32'(4 * k));
                    chk(int_wdata == mem(v.ea + 32'(4 * k)), "R3", int_wdata,
                        mem(v.ea + 32'(4 * k)));
                    k++;
                end
            end else begin
                int_rvalid = !s_st; int_rdata = mem(int_addr);
                ext_wready = !k_st;
                if (ext_wvalid && ext_wready) begin
                    chk(ext_addr == v.ea + 32'(4 * k), "R2", ext_addr, v.ea + 32'(4 * k));
                    chk(ext_wdata == mem(v.ia + 32'(4 * k)), "R2", ext_wdata,
                        mem(v.ia + 32'(4 * k)));
                    k++;
                end
            end
            if (irq) pulses++;
            @(negedge clk);
            cyc++;
        end
        idle_bus();
        chk(k == int'(v.cnt), "R2/R3 word count", k, v.cnt);
        for (int i = 0; i < 3; i++) begin
            if (irq) pulses++;
            @(negedge clk);
        end
        chk(pulses == ((v.cause == 2'b10) ? 1 : 0), "R8/R10 irq pulses", pulses,
            (v.cause == 2'b10) ? 1 : 0);
        rd_reg(2'd0, r);
        chk(r[31:16] == 16'd0, "R5 count", r, 32'd0);
        chk(r[1:0] == 2'b00 && r[5] == 1'b0, "R6 start/busy clear", r, {30'd0, 2'b00});
        chk(r[6] == (v.cause == 2'b10), "R8 sticky", {31'd0, r[6]}, {31'd0, v.cause == 2'b10});
        chk(ext_master == 1'b0, "R11 released", {31'd0, ext_master}, 32'd0);
        rd_reg(2'd1, r);
        chk(r == v.ia + 32'(4 * int'(v.cnt)), "R5 internal address", r,
            v.ia + 32'(4 * int'(v.cnt)));
        rd_reg(2'd2, r);
        chk(r == v.ea + 32'(4 * int'(v.cnt)), "R5 external address", r,
            v.ea + 32'(4 * int'(v.cnt)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, r); chk(r == 32'd0, "R1 ctrl", r, 32'd0);
        rd_reg(2'd1, r); chk(r == 32'd0, "R1 iadr", r, 32'd0);
        rd_reg(2'd2, r); chk(r == 32'd0, "R1 eadr", r, 32'd0);
        chk({irq, ext_master, int_rready, int_wvalid, ext_rready, ext_wvalid} == 6'd0,
            "R1 outputs", {26'd0, irq, ext_master, int_rready, int_wvalid, ext_rready,
            ext_wvalid}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R4 codes that start nothing
        wr_reg(2'd0, ctrl(16'd2, 2'b10, 2'b11, 1'b0, 1'b1));
        rd_reg(2'd0, r);
        chk(r[5] == 1'b0 && r[1:0] == 2'b00 && r[31:16] == 16'd2, "R4 code 11", r,
            {16'd2, 16'h0008});
        chk({int_rready, ext_rready, ext_master} == 3'd0, "R4 code 11 quiet",
            {29'd0, int_rready, ext_rready, ext_master}, 32'd0);
        wr_reg(2'd0, ctrl(16'd0, 2'b10, 2'b01, 1'b0, 1'b0));
        rd_reg(2'd0, r);
        chk(r[5] == 1'b0 && r[1:0] == 2'b00, "R4 zero count", r, 32'h0000_0008);
        wr_reg(2'd0, ctrl(16'd4, 2'b00, 2'b00, 1'b0, 1'b0));
        rd_reg(2'd0, r);
        chk(r[5] == 1'b0 && ext_master == 1'b0, "R4 code 00", r, {16'd4, 16'h0000});

        // R7 / R12 stalled sink with writes while busy
        wr_reg(2'd1, 32'h0000_1000);
        wr_reg(2'd2, 32'h0000_2000);
        int_rvalid = 1'b1; int_rdata = 32'hCAFE_0001; ext_wready = 1'b0;
        wr_reg(2'd0, ctrl(16'd3, 2'b00, 2'b01, 1'b0, 1'b0));
        repeat (3) @(negedge clk);
        chk(ext_wvalid == 1'b1 && ext_wdata == 32'hCAFE_0001, "R12 offered", ext_wdata,
            32'hCAFE_0001);
        int_rdata = 32'h1111_2222;
        repeat (3) @(negedge clk);
        chk(ext_wdata == 32'hCAFE_0001 && ext_addr == 32'h2000, "R12 held", ext_wdata,
            32'hCAFE_0001);
        wr_reg(2'd0, ctrl(16'd9, 2'b00, 2'b10, 1'b0, 1'b0));
        rd_reg(2'd0, r);
        chk(r[31:16] == 16'd3 && r[1:0] == 2'b01 && r[5] == 1'b1, "R7 ctrl ignored", r,
            {16'd3, 16'h0021});
        wr_reg(2'd1, 32'h0000_5555);
        rd_reg(2'd1, r);
        chk(r == 32'h0000_1000, "R7 address ignored", r, 32'h0000_1000);
        ext_wready = 1'b1;
        repeat (10) @(negedge clk);
        idle_bus();
        rd_reg(2'd0, r);
        chk(r[31:16] == 16'd0 && r[5] == 1'b0, "R6 stalled burst end", r, 32'd0);
        rd_reg(2'd2, r);
        chk(r == 32'h0000_200C, "R5 stalled burst eadr", r, 32'h0000_200C);

        // R9 doorbell with source 01
        wr_reg(2'd0, ctrl(16'd0, 2'b01, 2'b00, 1'b1, 1'b1));
        doorbell_set = 1'b1;
        @(negedge clk);
        doorbell_set = 1'b0;
        chk(irq == 1'b1, "R9 irq pulse", {31'd0, irq}, 32'd1);
        rd_reg(2'd0, r);
        chk(r[4] == 1'b1 && r[6] == 1'b1, "R9 bell and sticky", r, 32'h0000_0054);
        @(negedge clk);
        chk(irq == 1'b0, "R9 single pulse", {31'd0, irq}, 32'd0);
        wr_reg(2'd0, ctrl(16'd0, 2'b01, 2'b00, 1'b1, 1'b1));
        rd_reg(2'd0, r);
        chk(r[4] == 1'b0 && r[6] == 1'b0, "R8/R9 write-1 clear", r, 32'h0000_0004);

        // R10 doorbell with source 00 and 10
        for (int s = 0; s < 2; s++) begin
            int p = 0;
            wr_reg(2'd0, ctrl(16'd0, (s == 0) ? 2'b00 : 2'b10, 2'b00, 1'b1, 1'b1));
            doorbell_set = 1'b1;
            @(negedge clk);
            doorbell_set = 1'b0;
            if (irq) p++;
            @(negedge clk);
            if (irq) p++;
            chk(p == 0, "R10 doorbell masked", p, 0);
            rd_reg(2'd0, r);
            chk(r[4] == 1'b1 && r[6] == 1'b0, "R10 bell set, sticky clear", r,
                {25'd0, 1'b0, 2'b01, 4'd0});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule